// File: doc/BRIEF.md
# Metering Interrupt Event Detector

This block sits beside the datapath of a three-phase energy meter and converts selected changes in that datapath into interrupt requests. It monitors fifteen energy accumulators, the signed active and reactive power of each phase, the summed power feeding each of three pulse-output paths, the three internal pulse signals, a line-cycle integration strobe and a periodic compute-done strobe. It detects three kinds of change: toggles of one accumulator bit, sign reversals of sampled powers, and falling edges of pulses.

Each detected event sets its own sticky bit in a 19-bit status word, whether or not that event is enabled. Software enables events through a mask register. It reads the mask and status words, and clears status bits by writing ones, over a one-address-bit register bus. A single active-low interrupt line is low while any enabled status bit is set. The block also gates each pulse output with its disable input. Edge detection always looks at the pulse before that gate.

Top module: `meter_irq_detect`

## Requirements
- R1: Status bits 0 to 4 belong to the energy classes total active, fundamental active, total reactive, fundamental reactive and apparent. Class c, phase p is the accumulator at `acc_flat_i[(3c+p)*ACC_W +: ACC_W]`. A class bit sets when bit 30 of any of its three accumulators differs from its value on the previous clock. Changes in other bits have no effect. No toggle is reported on the first clock after reset.
- R2: Status bit 5 sets when `lcyc_done_i` is high while `lcyc_mode_i` is high. With the mode low, the strobe has no effect.
- R3: Status bits 6, 7 and 8 (phases A, B, C) set when the sign of the monitored active power differs from the sign held at the previous `pwr_vld_i` strobe. `act_sel_i`=0 selects total power and 1 selects fundamental power. Only strobed cycles compare and update the held sign. Zero counts as positive. The first strobe after reset only loads the held sign.
- R4: Status bits 10, 11 and 12 behave like R3 for reactive power, with their own select `rea_sel_i`.
- R5: Status bits 9, 13 and 18 behave like R3 for the summed power of pulse paths 1, 2 and 3 (`psum_i` slices 0, 1, 2).
- R6: Status bits 14 to 16 set on a high-to-low transition of internal pulse 1 to 3 (`cf_pulse_i`, active low). This holds even while `cf_dis_i` for that path is high, which keeps `cf_pin_o` high.
- R7: Status bit 17 sets on every cycle in which `dsp_done_i` is high.
- R8: Address 0 holds the mask and address 1 holds the status. The mask resets to 0. Bits 31:19 of both words read 0 and cannot be written.
- R9: Status bits stay set until a write of 1 to that bit at address 1. Bits set regardless of the mask.
- R10: An event in the same cycle as a clear of its status bit leaves that bit set.
- R11: `irq_n_o` is low exactly while some status bit and its mask bit are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Synchronous active-low reset |
| acc_flat_i | input | 15*ACC_W | Energy accumulators, class-major then phase |
| act_tot_i | input | 3*PWR_W | Total active power per phase, signed |
| act_fund_i | input | 3*PWR_W | Fundamental active power per phase, signed |
| rea_tot_i | input | 3*PWR_W | Total reactive power per phase, signed |
| rea_fund_i | input | 3*PWR_W | Fundamental reactive power per phase, signed |
| psum_i | input | 3*PWR_W | Summed power of pulse paths 1 to 3, signed |
| act_sel_i | input | 1 | 0 total, 1 fundamental active power |
| rea_sel_i | input | 1 | 0 total, 1 fundamental reactive power |
| pwr_vld_i | input | 1 | New power sample strobe |
| cf_pulse_i | input | 3 | Internal active-low pulses |
| cf_dis_i | input | 3 | Pulse output disables |
| cf_pin_o | output | 3 | Gated pulse outputs, high when disabled |
| lcyc_done_i | input | 1 | Line-cycle integration finished |
| lcyc_mode_i | input | 1 | Line-cycle accumulation mode active |
| dsp_done_i | input | 1 | Periodic computation finished |
| bus_we_i | input | 1 | Register write enable |
| bus_addr_i | input | 1 | 0 mask, 1 status |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for the addressed word |
| irq_n_o | output | 1 | Active-low interrupt |

## Verification
The bench places bit 30 of one accumulator high across the reset release. A detector that compares against a cleared history would then raise a false class event. It changes the sign of a non-selected power and moves a value while the strobe is low, which exposes a detector that ignores the select or compares every cycle. It steps a power from negative to exactly zero, which a detector treating zero as its own sign would miss. It also pulses a disabled output, where a design that looked at the gated pin would never see the edge. Finally, it raises the compute-done strobe in the cycle that clears its bit, where a clear-priority design would lose the event, and it writes the mask to zero, which must release the interrupt while the status bits stay set.

// File: rtl/mirq_pkg.sv
// Shared constants for the metering interrupt detector: event vector
// width and the position of each event group inside the status word.
package mirq_pkg;
    localparam int EV_W     = 19;   // implemented status/mask bits
    localparam int N_PH     = 3;    // phases / pulse paths
    localparam int N_CLS    = 5;    // energy classes
    localparam int EVB_LINE = 5;
    localparam int EVB_ACT0 = 6;
    localparam int EVB_REA0 = 10;
    localparam int EVB_CF0  = 14;
    localparam int EVB_DSP  = 17;

    typedef logic [EV_W-1:0] ev_vec_t;

    // Status bit of the sign event for summed pulse path i.
    function automatic int sum_bit(input int i);
        return (i == 0) ? 9 : ((i == 1) ? 13 : 18);
    endfunction
endpackage

// File: rtl/mirq_toggle_det.sv
// Toggle detector: flags when bit BIT of each of N words differs from its
// value one clock earlier. Assumes the words are synchronous to clk_i.
// The first clock after reset only loads the history.
module mirq_toggle_det #(
    parameter int N   = 15,
    parameter int W   = 32,
    parameter int BIT = 30
) (
    input  logic           clk_i,
    input  logic           rst_n_i,
    input  logic [N*W-1:0] word_i,
    output logic [N-1:0]   tog_o
);
    logic [N-1:0] cur_w;
    logic [N-1:0] prev_q;
    logic         primed_q;

    for (genvar g = 0; g < N; g++) begin : g_ch
        assign cur_w[g] = word_i[g*W + BIT];
        assign tog_o[g] = primed_q & (cur_w[g] ^ prev_q[g]);
    end

    // Hold last cycle's watched bits and mark history as valid.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            prev_q   <= '0;
            primed_q <= 1'b0;
        end else begin
            prev_q   <= cur_w;
            primed_q <= 1'b1;
        end
    end
endmodule

// File: rtl/mirq_sign_det.sv
// Sign-reversal detector for N signed samples of width W. A sample is
// compared with, and then replaces, the held sign only when vld_i is high.
// Zero has sign bit 0 and so counts as positive. The first strobe after
// reset only loads the held signs.
module mirq_sign_det #(
    parameter int N = 3,
    parameter int W = 24
) (
    input  logic           clk_i,
    input  logic           rst_n_i,
    input  logic           vld_i,
    input  logic [N*W-1:0] val_i,
    output logic [N-1:0]   flip_o
);
    logic [N-1:0] sgn_w;
    logic [N-1:0] held_q;
    logic         primed_q;

    for (genvar g = 0; g < N; g++) begin : g_ch
        assign sgn_w[g]  = val_i[g*W + W - 1];
        assign flip_o[g] = vld_i & primed_q & (sgn_w[g] ^ held_q[g]);
    end

    // Capture signs of each valid sample.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            held_q   <= '0;
            primed_q <= 1'b0;
        end else if (vld_i) begin
            held_q   <= sgn_w;
            primed_q <= 1'b1;
        end
    end
endmodule

// File: rtl/mirq_regs.sv
// Mask and sticky status registers with write-1-to-clear, bus read mux
// and interrupt output. A new event wins over a clear in the same cycle.
// Unimplemented bits read as zero.
module mirq_regs #(
    parameter int EV_W   = 19,
    parameter int DATA_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_n_i,
    input  logic [EV_W-1:0]   ev_i,
    input  logic              we_i,
    input  logic              addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic [EV_W-1:0]   status_o,
    output logic              irq_n_o
);
    logic [EV_W-1:0] mask_q;
    logic [EV_W-1:0] stat_q;
    logic [EV_W-1:0] clr_w;

    assign clr_w = (we_i && addr_i) ? wdata_i[EV_W-1:0] : '0;

    // Mask write and status set/clear.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            mask_q <= '0;
            stat_q <= '0;
        end else begin
            if (we_i && !addr_i) mask_q <= wdata_i[EV_W-1:0];
            stat_q <= (stat_q & ~clr_w) | ev_i;
        end
    end

    // Read mux with zero-filled reserved bits.
    always_comb begin
        rdata_o = '0;
        rdata_o[EV_W-1:0] = addr_i ? stat_q : mask_q;
    end

    assign status_o = stat_q;
    assign irq_n_o  = ~|(stat_q & mask_q);
endmodule

// File: rtl/meter_irq_detect.sv
// Top of the metering interrupt detector. Selects the monitored powers,
// runs toggle, sign and edge detectors, assembles the 19-bit event vector
// and feeds the register block. Pulse edges are taken before the disable
// gate, so a disabled output still reports events.
module meter_irq_detect
    import mirq_pkg::*;
#(
    parameter int ACC_W   = 32,
    parameter int TOG_BIT = 30,
    parameter int PWR_W   = 24,
    parameter int DATA_W  = 32
) (
    input  logic                     clk_i,
    input  logic                     rst_n_i,
    input  logic [N_CLS*N_PH*ACC_W-1:0] acc_flat_i,
    input  logic [N_PH*PWR_W-1:0]    act_tot_i,
    input  logic [N_PH*PWR_W-1:0]    act_fund_i,
    input  logic [N_PH*PWR_W-1:0]    rea_tot_i,
    input  logic [N_PH*PWR_W-1:0]    rea_fund_i,
    input  logic [N_PH*PWR_W-1:0]    psum_i,
    input  logic                     act_sel_i,
    input  logic                     rea_sel_i,
    input  logic                     pwr_vld_i,
    input  logic [N_PH-1:0]          cf_pulse_i,
    input  logic [N_PH-1:0]          cf_dis_i,
    output logic [N_PH-1:0]          cf_pin_o,
    input  logic                     lcyc_done_i,
    input  logic                     lcyc_mode_i,
    input  logic                     dsp_done_i,
    input  logic                     bus_we_i,
    input  logic                     bus_addr_i,
    input  logic [DATA_W-1:0]        bus_wdata_i,
    output logic [DATA_W-1:0]        bus_rdata_o,
    output logic                     irq_n_o
);
    localparam int N_ACC = N_CLS * N_PH;

    logic [N_ACC-1:0]        tog_w;
    logic [N_PH*PWR_W-1:0]   act_w;
    logic [N_PH*PWR_W-1:0]   rea_w;
    logic [N_PH-1:0]         act_flip_w;
    logic [N_PH-1:0]         rea_flip_w;
    logic [N_PH-1:0]         sum_flip_w;
    logic [N_PH-1:0]         cf_prev_q;
    logic [N_PH-1:0]         cf_fall_w;
    ev_vec_t                 ev_w;
    ev_vec_t                 status_w;

    assign act_w = act_sel_i ? act_fund_i : act_tot_i;
    assign rea_w = rea_sel_i ? rea_fund_i : rea_tot_i;

    mirq_toggle_det #(.N(N_ACC), .W(ACC_W), .BIT(TOG_BIT)) u_tog (
        .clk_i(clk_i), .rst_n_i(rst_n_i), .word_i(acc_flat_i), .tog_o(tog_w)
    );
    mirq_sign_det #(.N(N_PH), .W(PWR_W)) u_act (
        .clk_i(clk_i), .rst_n_i(rst_n_i), .vld_i(pwr_vld_i),
        .val_i(act_w), .flip_o(act_flip_w)
    );
    mirq_sign_det #(.N(N_PH), .W(PWR_W)) u_rea (
        .clk_i(clk_i), .rst_n_i(rst_n_i), .vld_i(pwr_vld_i),
        .val_i(rea_w), .flip_o(rea_flip_w)
    );
    mirq_sign_det #(.N(N_PH), .W(PWR_W)) u_sum (
        .clk_i(clk_i), .rst_n_i(rst_n_i), .vld_i(pwr_vld_i),
        .val_i(psum_i), .flip_o(sum_flip_w)
    );

    // Remember last pulse levels (idle high) for falling-edge detection.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) cf_prev_q <= '1;
        else          cf_prev_q <= cf_pulse_i;
    end

    assign cf_fall_w = cf_prev_q & ~cf_pulse_i;
    assign cf_pin_o  = cf_pulse_i | cf_dis_i;

    // Place every detector output at its status bit.
    always_comb begin
        ev_w = '0;
        for (int c = 0; c < N_CLS; c++) ev_w[c] = |tog_w[c*N_PH +: N_PH];
        ev_w[EVB_LINE] = lcyc_done_i & lcyc_mode_i;
        for (int p = 0; p < N_PH; p++) begin
            ev_w[EVB_ACT0 + p]  = act_flip_w[p];
            ev_w[EVB_REA0 + p]  = rea_flip_w[p];
            ev_w[EVB_CF0 + p]   = cf_fall_w[p];
            ev_w[sum_bit(p)]    = sum_flip_w[p];
        end
        ev_w[EVB_DSP] = dsp_done_i;
    end

    mirq_regs #(.EV_W(EV_W), .DATA_W(DATA_W)) u_regs (
        .clk_i(clk_i), .rst_n_i(rst_n_i), .ev_i(ev_w),
        .we_i(bus_we_i), .addr_i(bus_addr_i), .wdata_i(bus_wdata_i),
        .rdata_o(bus_rdata_o), .status_o(status_w), .irq_n_o(irq_n_o)
    );
endmodule

// File: rtl/mirq_checks.sv
// Checker for meter_irq_detect: temporal properties on the bus, the
// compute-done status bit and the interrupt line. Bound to the top below.
module mirq_checks #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              we,
    input logic              addr,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] rdata,
    input logic              dsp_done,
    input logic [18:0]       status,
    input logic              irq_n
);
    a_r8_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rdata[DATA_W-1:19] == '0);

    a_r7_dsp_sets: assert property (@(posedge clk) disable iff (!rst_n)
        dsp_done |=> status[17]);

    a_r10_event_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (dsp_done && we && addr && wdata[17]) |=> status[17]);

    a_r9_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr && wdata[17] && !dsp_done) |=> !status[17]);

    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (status[17] && !(we && addr && wdata[17])) |=> status[17]);

    a_r11_mask_zero_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !addr && wdata[18:0] == '0) |=> irq_n);
endmodule

bind meter_irq_detect mirq_checks #(.DATA_W(DATA_W)) u_chk (
    .clk(clk_i), .rst_n(rst_n_i), .we(bus_we_i), .addr(bus_addr_i),
    .wdata(bus_wdata_i), .rdata(bus_rdata_o), .dsp_done(dsp_done_i),
    .status(status_w), .irq_n(irq_n_o)
);

// File: tb/meter_irq_detect_bench.sv
// Bench: behavioural reference model stepped each clock, compared with the
// interrupt line and status readback every cycle, plus directed checks.
module meter_irq_detect_bench;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst_n = 1'b0;
    logic [31:0] acc [15];
    logic [23:0] act_t [3], act_f [3], rea_t [3], rea_f [3], psum [3];
    logic [479:0] acc_flat;
    logic [71:0] act_t_f, act_f_f, rea_t_f, rea_f_f, psum_f;
    logic act_sel = 0, rea_sel = 0, vld = 0;
    logic [2:0] cf_pulse = 3'b111, cf_dis = 3'b000, cf_pin;
    logic lcyc_done = 0, lcyc_mode = 0, dsp = 0;
    logic bus_we = 0, bus_addr = 0;
    logic [31:0] bus_wdata = 0, bus_rdata;
    logic irq_n;

    always_comb begin
        for (int i = 0; i < 15; i++) acc_flat[i*32 +: 32] = acc[i];
        for (int p = 0; p < 3; p++) begin
            act_t_f[p*24 +: 24] = act_t[p];
            act_f_f[p*24 +: 24] = act_f[p];
            rea_t_f[p*24 +: 24] = rea_t[p];
            rea_f_f[p*24 +: 24] = rea_f[p];
            psum_f[p*24 +: 24]  = psum[p];
        end
    end

    meter_irq_detect u_meter_irq_detect (
        .clk_i(clk), .rst_n_i(rst_n), .acc_flat_i(acc_flat),
        .act_tot_i(act_t_f), .act_fund_i(act_f_f), .rea_tot_i(rea_t_f),
        .rea_fund_i(rea_f_f), .psum_i(psum_f), .act_sel_i(act_sel),
        .rea_sel_i(rea_sel), .pwr_vld_i(vld), .cf_pulse_i(cf_pulse),
        .cf_dis_i(cf_dis), .cf_pin_o(cf_pin), .lcyc_done_i(lcyc_done),
        .lcyc_mode_i(lcyc_mode), .dsp_done_i(dsp), .bus_we_i(bus_we),
        .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata),
        .bus_rdata_o(bus_rdata), .irq_n_o(irq_n)
    );

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    // Reference model state.
    logic [18:0] m_status, m_mask;
    logic [14:0] m_pbit;
    logic [8:0]  m_psign;
    logic [2:0]  m_pcf;
    bit m_primed, m_pprimed;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Advance the model by one clock using the inputs now applied.
    task automatic model_step();
        logic [18:0] ev;
        logic s;
        int sb [3];
        sb[0] = 9; sb[1] = 13; sb[2] = 18;
        ev = '0;
        if (!rst_n) begin
            m_status = 0; m_mask = 0; m_primed = 0; m_pprimed = 0;
            m_pbit = 0; m_psign = 0; m_pcf = 3'b111;
            return;
        end
        for (int i = 0; i < 15; i++) begin
            if (m_primed && acc[i][30] != m_pbit[i]) ev[i/3] = 1'b1;
            m_pbit[i] = acc[i][30];
        end
        m_primed = 1;
        if (lcyc_done && lcyc_mode) ev[5] = 1'b1;
        if (vld) begin
            for (int p = 0; p < 3; p++) begin
                s = act_sel ? act_f[p][23] : act_t[p][23];
                if (m_pprimed && s != m_psign[p]) ev[6+p] = 1'b1;
                m_psign[p] = s;
                s = rea_sel ? rea_f[p][23] : rea_t[p][23];
                if (m_pprimed && s != m_psign[3+p]) ev[10+p] = 1'b1;
                m_psign[3+p] = s;
                s = psum[p][23];
                if (m_pprimed && s != m_psign[6+p]) ev[sb[p]] = 1'b1;
                m_psign[6+p] = s;
            end
            m_pprimed = 1;
        end
        for (int i = 0; i < 3; i++) begin
            if (m_pcf[i] && !cf_pulse[i]) ev[14+i] = 1'b1;
            m_pcf[i] = cf_pulse[i];
        end
        if (dsp) ev[17] = 1'b1;
        if (bus_we && bus_addr) m_status = (m_status & ~bus_wdata[18:0]) | ev;
        else                    m_status = m_status | ev;
        if (bus_we && !bus_addr) m_mask = bus_wdata[18:0];
    endtask

    // One clock: model step, edge, then compare at the falling edge.
    task automatic tick();
        logic sa;
        model_step();
        @(posedge clk);
        @(negedge clk);
        chk("R11 irq_n", {31'b0, irq_n}, {31'b0, ~|(m_status & m_mask)});
        if (!bus_we) begin
            sa = bus_addr;
            bus_addr = 1'b1;
            #1;
            chk("R9 status", bus_rdata, {13'b0, m_status});
            bus_addr = sa;
        end
    endtask

    task automatic wr(input logic a, input logic [31:0] d);
        bus_we = 1; bus_addr = a; bus_wdata = d;
        tick();
        bus_we = 0; bus_wdata = 0;
    endtask

    task automatic rd(input logic a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        #200000;
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        for (int i = 0; i < 15; i++) acc[i] = 0;
        for (int p = 0; p < 3; p++) begin
            act_t[p] = 0; act_f[p] = 0; rea_t[p] = 0; rea_f[p] = 0; psum[p] = 0;
        end
        acc[4] = 32'h4000_0000;         // bit 30 high across reset release
        @(negedge clk);
        repeat (3) tick();
        rst_n = 1;
        tick(); tick();
        rd(1, d); chk("R1 no toggle after reset", d, 0);
        rd(0, d); chk("R8 mask reset", d, 0);
        chk("R11 idle high", {31'b0, irq_n}, 1);

        wr(0, 32'hFFFF_FFFF);
        rd(0, d); chk("R8 reserved read zero", d, 32'h0007_FFFF);

        acc[0] = 32'h0000_0005; tick();
        rd(1, d); chk("R1 low bits ignored", d, 0);
        acc[7] = 32'h4000_0000; tick();
        rd(1, d); chk("R1 class 2 toggle", d, 32'h4);
        chk("R11 irq low", {31'b0, irq_n}, 0);
        wr(1, 32'hFFFF_FFFF);
        rd(1, d); chk("R9 clear all", d, 0);

        lcyc_done = 1; lcyc_mode = 0; tick(); lcyc_done = 0;
        rd(1, d); chk("R2 mode off", d[5], 0);
        lcyc_done = 1; lcyc_mode = 1; tick(); lcyc_done = 0;
        rd(1, d); chk("R2 mode on", d[5], 1);
        wr(1, 32'hFFFF_FFFF);

        vld = 1; tick();                 // prime held signs
        act_t[0] = -24'sd5; tick();
        rd(1, d); chk("R3 phase A flip", d[6], 1);
        act_f[1] = -24'sd3; tick();
        rd(1, d); chk("R3 unselected ignored", d[7], 0);
        vld = 0;
        wr(1, 32'hFFFF_FFFF);
        act_t[0] = 0; tick();
        rd(1, d); chk("R3 no strobe no compare", d[6], 0);
        vld = 1; tick();
        rd(1, d); chk("R3 zero is positive", d[6], 1);
        vld = 0;
        wr(1, 32'hFFFF_FFFF);
        act_sel = 1; vld = 1; tick();
        rd(1, d); chk("R3 fundamental selected", d[8:6], 3'b010);
        rea_t[2] = -24'sd1; tick();
        rd(1, d); chk("R4 reactive phase C", d[12:10], 3'b100);
        psum[1] = -24'sd9; tick();
        rd(1, d); chk("R5 path 2 sum", d[13], 1);
        psum[2] = -24'sd2; tick();
        rd(1, d); chk("R5 path 3 sum", d[18], 1);
        chk("R5 path 1 quiet", d[9], 0);
        vld = 0;
        wr(1, 32'hFFFF_FFFF);

        cf_dis = 3'b001; cf_pulse = 3'b110; #1;
        chk("R6 disabled pin high", cf_pin, 3'b111);
        tick();
        rd(1, d); chk("R6 edge while disabled", d[16:14], 3'b001);
        cf_pulse = 3'b111; cf_dis = 0; tick();

        dsp = 1; tick();
        rd(1, d); chk("R7 compute done", d[17], 1);
        wr(1, 32'h0002_0000);
        dsp = 0;
        rd(1, d); chk("R10 event beats clear", d[17], 1);
        wr(1, 32'h0002_0000);
        rd(1, d); chk("R9 clear single bit", d[17], 0);

        wr(1, 32'hFFFF_FFFF);
        wr(0, 32'h0);
        dsp = 1; tick(); dsp = 0;
        rd(1, d); chk("R9 set while masked", d[17], 1);
        chk("R11 masked no irq", {31'b0, irq_n}, 1);
        wr(0, 32'h0002_0000);
        chk("R11 unmask asserts", {31'b0, irq_n}, 0);
        tick();
        finish_run();
    end
endmodule